// File: doc/BRIEF.md
# Poison-Tagged Speculative Store Queue

This unit connects the address-generating half of a decoupled access/execute datapath to its compute half. The address half runs ahead and pushes every store address it might need into an address queue, including stores that may never execute. Later, the compute half pushes one value for each of those addresses, in the same order. Each value carries a one-bit poison tag that says whether the store really happens.

The unit pairs the head of the address queue with the head of the value queue, strictly in order. A pair with a clear tag becomes one write on a simple synchronous memory port. A pair with the tag set is consumed silently: its address leaves the queue and no write occurs. There is no rollback path. Two counters report how many stores were written and how many were dropped. An idle flag shows when nothing is queued and no write is outstanding.

Top module: `poison_store_unit`

## Requirements
- R1: A synchronous active-high reset empties both queues, clears both counters and drops memWe. While and after reset, idle is 1 and both ready outputs are 1.
- R2: The address queue accepts a push (addrValid and addrReady both 1 at a clock edge) until it holds DEPTH entries. addrReady is then 0, and an address offered while it is 0 is not stored.
- R3: The value queue behaves the same way, with valValid and valReady, holding at most DEPTH entries.
- R4: A pair is processed only when both queues hold at least one entry. With one queue empty, no write occurs and the other queue keeps its entries.
- R5: A pair whose poison tag is 0 drives memWe high for exactly one cycle, together with that pair's address on memAddr and its value on memWdata. This happens in the cycle after the clock edge at which both queue heads were valid.
- R6: A pair whose poison tag is 1 produces no write, consumes its address and its value, and raises discardCount by one.
- R7: Writes appear on the memory port in the order in which their addresses were pushed.
- R8: commitCount rises by one for each write and discardCount by one for each dropped pair. Both counters update at the same clock edge as the pop.
- R9: idle is 1 exactly when both queues are empty and memWe is 0.
- R10: At most one pair is processed per cycle. When both queues are supplied every cycle, one pair is processed every cycle with no bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addrValid | input | 1 | Address push request |
| addrReady | output | 1 | Address queue has room |
| addrIn | input | ADDR_W | Speculative store address |
| valValid | input | 1 | Value push request |
| valReady | output | 1 | Value queue has room |
| valData | input | DATA_W | Store value |
| valPoison | input | 1 | 1 drops the store, 0 commits it |
| memWe | output | 1 | Memory write enable, one cycle per committed store |
| memAddr | output | ADDR_W | Memory write address |
| memWdata | output | DATA_W | Memory write data |
| commitCount | output | CNT_W | Number of committed stores |
| discardCount | output | CNT_W | Number of dropped stores |
| idle | output | 1 | Both queues empty and no write in flight |

## Verification
The stream test pushes address/value pairs together, one per cycle, with an irregular mix of clear and set tags. It checks that only the clear-tagged addresses reach memory, in push order, with write times that follow the push times cycle for cycle. That last check separates a pipeline that keeps full rate from one that inserts bubbles.

A second pattern fills the address queue alone and then offers one more address, which must be refused. Values arriving afterwards then show which addresses were actually kept, and that nothing moved while the value side was empty. Filling the value queue alone checks its backpressure. A reset issued while entries are queued must leave nothing behind, which shows up in the write produced by the next pair.

// File: rtl/pstore_pkg.sv
package pstore_pkg;
  // strobes issued by the control to the datapath for one cycle
  typedef struct packed {
    logic popPair;
    logic commit;
    logic discard;
  } strobe_t;
endpackage

// File: rtl/pstore_fifo.sv
module pstore_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pushValid,
  output logic             pushReady,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popEn,
  output logic             headValid,
  output logic [WIDTH-1:0] headData
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0]  slots [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [FILL_W-1:0] fill;
  logic doPush, doPop;

  assign pushReady = (fill != FILL_W'(DEPTH));
  assign headValid = (fill != '0);
  assign headData  = slots[rdPtr];
  assign doPush    = pushValid & pushReady;
  assign doPop     = popEn & headValid;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) slots[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= '0;
      wrPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   fill <= fill + FILL_W'(1);
        2'b01:   fill <= fill - FILL_W'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/pstore_ctrl.sv
module pstore_ctrl
  import pstore_pkg::*;
(
  input  logic    addrHeadValid,
  input  logic    valHeadValid,
  input  logic    headPoison,
  output strobe_t strobe
);
  always_comb begin
    strobe.popPair = addrHeadValid & valHeadValid;
    strobe.commit  = strobe.popPair & ~headPoison;
    strobe.discard = strobe.popPair & headPoison;
  end
endmodule

// File: rtl/pstore_datapath.sv
module pstore_datapath
  import pstore_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addrValid,
  output logic              addrReady,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              valValid,
  output logic              valReady,
  input  logic [DATA_W-1:0] valData,
  input  logic              valPoison,
  input  strobe_t           strobe,
  output logic              addrHeadValid,
  output logic              valHeadValid,
  output logic              headPoison,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [CNT_W-1:0]  commitCount,
  output logic [CNT_W-1:0]  discardCount,
  output logic              idle
);
  localparam int VAL_W = DATA_W + 1;

  logic [ADDR_W-1:0] addrHead;
  logic [VAL_W-1:0]  valHead;

  pstore_fifo #(.WIDTH(ADDR_W), .DEPTH(DEPTH)) i_addrQ (
    .clk(clk), .rst(rst),
    .pushValid(addrValid), .pushReady(addrReady), .pushData(addrIn),
    .popEn(strobe.popPair), .headValid(addrHeadValid), .headData(addrHead)
  );

  pstore_fifo #(.WIDTH(VAL_W), .DEPTH(DEPTH)) i_valQ (
    .clk(clk), .rst(rst),
    .pushValid(valValid), .pushReady(valReady), .pushData({valPoison, valData}),
    .popEn(strobe.popPair), .headValid(valHeadValid), .headData(valHead)
  );

  assign headPoison = valHead[DATA_W];
  assign idle = ~addrHeadValid & ~valHeadValid & ~memWe;

  always_ff @(posedge clk) begin
    if (rst) begin
      memWe        <= 1'b0;
      memAddr      <= '0;
      memWdata     <= '0;
      commitCount  <= '0;
      discardCount <= '0;
    end else begin
      memWe <= strobe.commit;
      if (strobe.commit) begin
        memAddr     <= addrHead;
        memWdata    <= valHead[DATA_W-1:0];
        commitCount <= commitCount + CNT_W'(1);
      end
      if (strobe.discard) discardCount <= discardCount + CNT_W'(1);
    end
  end
endmodule

// File: rtl/poison_store_unit.sv
module poison_store_unit
  import pstore_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addrValid,
  output logic              addrReady,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              valValid,
  output logic              valReady,
  input  logic [DATA_W-1:0] valData,
  input  logic              valPoison,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [CNT_W-1:0]  commitCount,
  output logic [CNT_W-1:0]  discardCount,
  output logic              idle
);
  strobe_t strobe;
  logic addrHeadValid, valHeadValid, headPoison;

  pstore_ctrl i_ctrl (
    .addrHeadValid(addrHeadValid), .valHeadValid(valHeadValid),
    .headPoison(headPoison), .strobe(strobe)
  );

  pstore_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rst(rst),
    .addrValid(addrValid), .addrReady(addrReady), .addrIn(addrIn),
    .valValid(valValid), .valReady(valReady), .valData(valData), .valPoison(valPoison),
    .strobe(strobe),
    .addrHeadValid(addrHeadValid), .valHeadValid(valHeadValid), .headPoison(headPoison),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .commitCount(commitCount), .discardCount(discardCount), .idle(idle)
  );
endmodule

// File: rtl/pstore_checker.sv
module pstore_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             addrReady,
  input logic             valReady,
  input logic             memWe,
  input logic [CNT_W-1:0] commitCount,
  input logic [CNT_W-1:0] discardCount,
  input logic             idle
);
  // a full address queue is never idle
  p_addr_full_busy_r2: assert property (@(posedge clk) disable iff (rst)
    !addrReady |-> !idle);

  // a full value queue is never idle
  p_val_full_busy_r3: assert property (@(posedge clk) disable iff (rst)
    !valReady |-> !idle);

  // a dropped pair never coincides with a write
  p_discard_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (discardCount != $past(discardCount)) |-> !memWe);

  // each write advances the commit counter by exactly one
  p_commit_step_r8: assert property (@(posedge clk) disable iff (rst)
    memWe |-> commitCount == $past(commitCount) + CNT_W'(1));

  // counters never step by more than one per cycle
  p_one_pair_per_cycle_r10: assert property (@(posedge clk) disable iff (rst)
    (commitCount + discardCount) - ($past(commitCount) + $past(discardCount)) <= CNT_W'(1));

  // nothing queued means nothing to write next cycle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    idle |=> !memWe);
endmodule

bind poison_store_unit pstore_checker #(.CNT_W(CNT_W)) i_pstore_checker (
  .clk(clk), .rst(rst), .addrReady(addrReady), .valReady(valReady),
  .memWe(memWe), .commitCount(commitCount), .discardCount(discardCount), .idle(idle)
);

// File: tb/test_poison_store_unit.sv
module test_poison_store_unit;
  localparam int DEPTH = 4, ADDR_W = 16, DATA_W = 32, CNT_W = 16;
  localparam int NV = 10;
  localparam int VW = 1 + ADDR_W + DATA_W;
  // {poison, address, value}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 16'h0010, 32'hA000_0001}, {1'b1, 16'h0011, 32'hA000_0002},
    {1'b0, 16'h0012, 32'hA000_0003}, {1'b0, 16'h0013, 32'hA000_0004},
    {1'b1, 16'h0014, 32'hA000_0005}, {1'b1, 16'h0015, 32'hA000_0006},
    {1'b0, 16'h0016, 32'hA000_0007}, {1'b1, 16'h0017, 32'hA000_0008},
    {1'b0, 16'h0018, 32'hA000_0009}, {1'b0, 16'h0019, 32'hA000_000A}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic addrValid = 1'b0, valValid = 1'b0, valPoison = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [DATA_W-1:0] valData = '0;
  logic addrReady, valReady, memWe, idle;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic [CNT_W-1:0]  commitCount, discardCount;

  always #5 clk = ~clk;

  poison_store_unit #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_poison_store_unit (
    .clk(clk), .rst(rst), .addrValid(addrValid), .addrReady(addrReady), .addrIn(addrIn),
    .valValid(valValid), .valReady(valReady), .valData(valData), .valPoison(valPoison),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .commitCount(commitCount), .discardCount(discardCount), .idle(idle)
  );

  // write log captured by a monitor away from the active edge
  int cyc = 0;
  int logCount = 0;
  logic [ADDR_W-1:0] logAddr [64];
  logic [DATA_W-1:0] logData [64];
  int logCyc [64];
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (memWe && logCount < 64) begin
      logAddr[logCount] <= memAddr;
      logData[logCount] <= memWdata;
      logCyc[logCount]  <= cyc;
      logCount <= logCount + 1;
    end
  end

  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic pushPair(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic p);
    addrValid = 1'b1; addrIn = a; valValid = 1'b1; valData = d; valPoison = p;
    @(posedge clk); @(negedge clk);
    addrValid = 1'b0; valValid = 1'b0;
  endtask

  task automatic pushAddr(input logic [ADDR_W-1:0] a);
    addrValid = 1'b1; addrIn = a;
    @(posedge clk); @(negedge clk);
    addrValid = 1'b0;
  endtask

  task automatic pushVal(input logic [DATA_W-1:0] d, input logic p);
    valValid = 1'b1; valData = d; valPoison = p;
    @(posedge clk); @(negedge clk);
    valValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    endRun();
  end

  initial begin
    int base, k, firstIdx, firstLog;
    doReset();
    #1;
    // R1: reset state
    check("R1 commitCount", commitCount, 0);
    check("R1 discardCount", discardCount, 0);
    check("R1 memWe", memWe, 0);
    check("R1 idle", idle, 1);
    check("R1 ready", {addrReady, valReady}, 2'b11);

    // stream walk: pairs pushed together, one per cycle
    base = logCount;
    @(negedge clk);
    for (int i = 0; i < NV; i++)
      pushPair(VEC[i][VW-2 -: ADDR_W], VEC[i][DATA_W-1:0], VEC[i][VW-1]);
    repeat (3) settle();
    k = base; firstIdx = -1; firstLog = 0;
    for (int i = 0; i < NV; i++) begin
      if (!VEC[i][VW-1]) begin
        check("R5/R7 address", logAddr[k], VEC[i][VW-2 -: ADDR_W]);
        check("R5 value", logData[k], VEC[i][DATA_W-1:0]);
        if (firstIdx < 0) begin firstIdx = i; firstLog = logCyc[k]; end
        else check("R10 write cycle", logCyc[k] - firstLog, i - firstIdx);
        k++;
      end
    end
    check("R6 write count", logCount - base, 6);
    check("R8 commitCount", commitCount, 6);
    check("R8 discardCount", discardCount, 4);
    check("R9 idle after drain", idle, 1);

    // address queue alone: fill, then one refused push
    doReset();
    base = logCount;
    for (int i = 0; i < DEPTH; i++) pushAddr(ADDR_W'(16'h0100 + i));
    #1;
    check("R2 addrReady full", addrReady, 0);
    check("R9 idle with queued address", idle, 0);
    pushAddr(16'h0BAD);
    settle();
    check("R4 no write without values", logCount - base, 0);
    check("R4 commitCount", commitCount, 0);
    pushVal(32'hB000_0000, 1'b1);
    pushVal(32'hB000_0001, 1'b0);
    pushVal(32'hB000_0002, 1'b0);
    pushVal(32'hB000_0003, 1'b1);
    repeat (3) settle();
    check("R6 writes with drops", logCount - base, 2);
    check("R7 first kept address", logAddr[base], 16'h0101);
    check("R7 second kept address", logAddr[base + 1], 16'h0102);
    check("R5 second value", logData[base + 1], 32'hB000_0002);
    check("R8 discardCount", discardCount, 2);
    check("R2 refused address gone", idle, 1);
    pushVal(32'hB000_0004, 1'b0);
    repeat (2) settle();
    check("R4 lone value held", logCount - base, 2);
    check("R9 idle with queued value", idle, 0);

    // value queue alone fills; reset clears queued entries
    doReset();
    for (int i = 0; i < DEPTH; i++) pushVal(DATA_W'(i), 1'b0);
    #1;
    check("R3 valReady full", valReady, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); #1;
    check("R1 ready after reset", {addrReady, valReady}, 2'b11);
    check("R1 idle after reset", idle, 1);
    @(negedge clk); rst = 1'b0;
    base = logCount;
    pushAddr(16'h0200);
    pushVal(32'hC0DE_0001, 1'b0);
    repeat (2) settle();
    check("R1 stale values flushed", logData[base], 32'hC0DE_0001);
    check("R8 single commit", commitCount, 1);
    endRun();
  end
endmodule